// File: doc/BRIEF.md
# Sub-Word Access Bridge

The bridge sits between a processor-side memory port and a word-wide external port that selects bytes with a lane mask. The processor issues byte, half-word or word reads and writes. Each access carries an offset into a window that starts at a configured base address. The bridge decides whether to take the access. If it takes it, it forms the absolute address, clears the two low bits to get the word address, and builds a 4-bit lane mask. It then moves the data into the matching lanes on a write, or out of them on a read.

A register bank holds the configuration: base, window size, a device enable, one enable per access size and a byte-swap option. A single `cfg_load` strobe loads it, and reset restores its parameter defaults. An access the bridge does not claim is answered with zero data and a not-selected flag. An access it claims but rejects is answered the same way with its own flag. A rejected access never produces an external transaction. An accepted access produces exactly one external transaction, which waits for an acknowledge.

Top module: `subword_bridge`

## Requirements
- R1: After reset `req_ready` is 1 and `ext_valid` and `rsp_valid` are 0. The defaults (device on, all three size enables on, base 0, size 0) leave every access not claimed.
- R2: The external address is (base + offset) with bits [1:0] forced to 0. It stays stable while `ext_valid` waits for `ext_ack`.
- R3: A byte access (`req_size` 2'b00) sets only mask bit a[1:0], where a is the absolute address. The write byte `req_wdata[7:0]` goes to lane a[1:0], which is bits 8*a[1:0]+7 down to 8*a[1:0], and every other lane is driven to 0. A read returns that lane zero-extended in `rsp_rdata[7:0]`.
- R4: A half-word access (2'b01) uses mask 4'b0011 when a[1] is 0 and 4'b1100 when a[1] is 1. Without swap, the lower byte of the data sits in the lower lane. A word access (2'b10) uses mask 4'b1111, with processor byte i in lane i.
- R5: A half-word access with offset bit 0 set, or a word access with either offset bit [1:0] set, is misaligned. It gets a response with zero data and a `flag_align` pulse, and no external transaction.
- R6: An access whose offset is greater than or equal to the window size gets zero data and a `flag_range` pulse, and no external transaction.
- R7: The bridge does not claim an access if the device is off, the size is 0, all size enables are off, the enable for the access's size is off (bit 0 byte, bit 1 half, bit 2 word), or the size code is 2'b11. Such an access gets zero data and a `flag_nosel` pulse, and no external transaction.
- R8: With swap set, half-word and word data have their byte order reversed between the processor and external sides, on writes and on reads. Byte accesses are unchanged by swap.
- R9: `req_ready` is 0 from acceptance until the response. Each accepted access gives at most one external transaction. `rsp_valid` pulses for one cycle, one cycle after the acknowledge cycle, or one cycle after acceptance for a rejection. A write returns zero data.
- R10: The rejection checks have a fixed priority: not-claimed first, then out-of-window, then misaligned. At most one flag pulses, always together with `rsp_valid`. A configuration load during an outstanding transaction does not change that transaction's steering or swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Load the cfg_* values into the configuration bank |
| cfg_base | input | ADDR_W | Window base address |
| cfg_size | input | ADDR_W | Window size in bytes |
| cfg_dev_en | input | 1 | Device enable |
| cfg_size_en | input | 3 | Size enables: bit 0 byte, bit 1 half-word, bit 2 word |
| cfg_swap | input | 1 | Byte-order swap for half-word and word data |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Bridge idle, request accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_offset | input | ADDR_W | Offset inside the window |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data, right-justified, zero when rejected |
| ext_valid | output | 1 | External transaction pending |
| ext_write | output | 1 | External transaction is a write |
| ext_addr | output | ADDR_W | Word-aligned external address |
| ext_mask | output | 4 | Lane mask |
| ext_wdata | output | 32 | Lane-placed write data |
| ext_ack | input | 1 | External acknowledge |
| ext_rdata | input | 32 | External read word, valid with ext_ack |
| flag_nosel | output | 1 | Pulse: access not claimed |
| flag_range | output | 1 | Pulse: offset outside the window |
| flag_align | output | 1 | Pulse: misaligned access |

## Verification
A configuration load can land on the same clock edge as the external acknowledge of a transaction still in flight. At that edge the bridge extracts read data with the swap state captured at acceptance, while the register bank takes the new swap value. The bench starts a half-word read with the acknowledge delay set to zero and loads a flipped swap setting as soon as `ext_valid` rises, so the load and the acknowledge coincide. The returned data must match the old byte order, and the next access must use the new one.

// File: rtl/subword_bridge_pkg.sv
package subword_bridge_pkg;

  localparam int LANES = 4;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    VD_GO    = 2'd0,
    VD_NOSEL = 2'd1,
    VD_RANGE = 2'd2,
    VD_ALIGN = 2'd3
  } verdict_e;

  // number of lanes an access of this size covers (0 for reserved)
  function automatic logic [2:0] width_of(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // lowest lane touched, from the absolute address low bits
  function automatic logic [1:0] first_lane(input logic [1:0] sz, input logic [1:0] low);
    case (sz)
      SZ_BYTE: return low;
      SZ_HALF: return {low[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] low);
    logic [2:0] w;
    logic [2:0] f;
    logic [LANES-1:0] m;
    w = width_of(sz);
    f = {1'b0, first_lane(sz, low)};
    m = '0;
    for (int k = 0; k < LANES; k++) begin
      if (3'(k) >= f && 3'(k) < f + w) m[k] = 1'b1;
    end
    return m;
  endfunction

  // external lane that holds processor byte position pos
  function automatic logic [1:0] lane_of_pos(input logic [1:0] sz, input logic [1:0] low,
                                             input logic swap, input logic [1:0] pos);
    logic [2:0] w;
    logic [1:0] rel;
    w = width_of(sz);
    rel = swap ? 2'(w - 3'd1 - {1'b0, pos}) : pos;
    return first_lane(sz, low) + rel;
  endfunction

  // processor byte position that feeds external lane ln
  function automatic logic [1:0] pos_of_lane(input logic [1:0] sz, input logic [1:0] low,
                                             input logic swap, input logic [1:0] ln);
    logic [2:0] w;
    logic [1:0] rel;
    w = width_of(sz);
    rel = ln - first_lane(sz, low);
    return swap ? 2'(w - 3'd1 - {1'b0, rel}) : rel;
  endfunction

  function automatic logic misaligned(input logic [1:0] sz, input logic [1:0] off_low);
    case (sz)
      SZ_HALF: return off_low[0];
      SZ_WORD: return |off_low;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bridge_cfg.sv
module bridge_cfg #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RST_BASE = '0,
  parameter logic [ADDR_W-1:0] RST_SIZE = '0,
  parameter logic RST_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_size,
  input  logic              in_dev_en,
  input  logic [2:0]        in_size_en,
  input  logic              in_swap,
  output logic [ADDR_W-1:0] cur_base,
  output logic [ADDR_W-1:0] cur_size,
  output logic              cur_dev_en,
  output logic [2:0]        cur_size_en,
  output logic              cur_swap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_base    <= RST_BASE;
      cur_size    <= RST_SIZE;
      cur_dev_en  <= 1'b1;
      cur_size_en <= 3'b111;
      cur_swap    <= RST_SWAP;
    end else if (load) begin
      cur_base    <= in_base;
      cur_size    <= in_size;
      cur_dev_en  <= in_dev_en;
      cur_size_en <= in_size_en;
      cur_swap    <= in_swap;
    end
  end

endmodule

// File: rtl/bridge_screen.sv
module bridge_screen
  import subword_bridge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic              dev_en,
  input  logic [2:0]        size_en,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] offset,
  output verdict_e          verdict,
  output logic [ADDR_W-1:0] abs_addr
);

  logic size_allowed;
  logic claimed;
  logic outside;
  logic bad_align;

  always_comb begin
    case (acc_size)
      SZ_BYTE: size_allowed = size_en[0];
      SZ_HALF: size_allowed = size_en[1];
      SZ_WORD: size_allowed = size_en[2];
      default: size_allowed = 1'b0;
    endcase
  end

  assign claimed   = dev_en && (size != '0) && (|size_en) && size_allowed;
  assign outside   = (offset >= size);
  assign bad_align = misaligned(acc_size, offset[1:0]);
  assign abs_addr  = base + offset;

  always_comb begin
    if (!claimed)       verdict = VD_NOSEL;
    else if (outside)   verdict = VD_RANGE;
    else if (bad_align) verdict = VD_ALIGN;
    else                verdict = VD_GO;
  end

endmodule

// File: rtl/bridge_lanes.sv
module bridge_lanes
  import subword_bridge_pkg::*;
(
  input  logic [1:0]              acc_size,
  input  logic [1:0]              low,
  input  logic                    swap,
  input  logic [LANES*LANE_W-1:0] proc_wdata,
  input  logic [LANES*LANE_W-1:0] ext_rdata,
  output logic [LANES-1:0]        mask,
  output logic [LANES*LANE_W-1:0] ext_wdata,
  output logic [LANES*LANE_W-1:0] proc_rdata
);

  assign mask = lane_mask(acc_size, low);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] src_pos;
    logic [1:0] rd_lane;
    assign src_pos = pos_of_lane(acc_size, low, swap, 2'(k));
    assign rd_lane = lane_of_pos(acc_size, low, swap, 2'(k));
    assign ext_wdata[LANE_W*k +: LANE_W] =
      mask[k] ? proc_wdata[LANE_W*src_pos +: LANE_W] : '0;
    assign proc_rdata[LANE_W*k +: LANE_W] =
      (3'(k) < width_of(acc_size)) ? ext_rdata[LANE_W*rd_lane +: LANE_W] : '0;
  end

endmodule

// File: rtl/subword_bridge.sv
module subword_bridge
  import subword_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RST_BASE = '0,
  parameter logic [ADDR_W-1:0] RST_SIZE = '0,
  parameter logic RST_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic              cfg_dev_en,
  input  logic [2:0]        cfg_size_en,
  input  logic              cfg_swap,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              ext_valid,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [3:0]        ext_mask,
  output logic [31:0]       ext_wdata,
  input  logic              ext_ack,
  input  logic [31:0]       ext_rdata,
  output logic              flag_nosel,
  output logic              flag_range,
  output logic              flag_align
);

  localparam int DW = LANES * LANE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_RSP} state_e;

  state_e            state;
  logic [ADDR_W-1:0] cur_base, cur_size;
  logic              cur_dev_en, cur_swap;
  logic [2:0]        cur_size_en;
  verdict_e          verdict;
  logic [ADDR_W-1:0] abs_addr;

  // transaction context captured at acceptance
  logic [1:0] t_size, t_low;
  logic       t_swap, t_write;

  // lane steering inputs: live request while idle, captured context otherwise
  logic [1:0]    st_size, st_low;
  logic          st_swap;
  logic [3:0]    st_mask;
  logic [DW-1:0] st_wdata, st_rdata;

  // named events for the checker
  logic accept_evt, go_evt, drop_evt, done_evt;

  bridge_cfg #(
    .ADDR_W(ADDR_W), .RST_BASE(RST_BASE), .RST_SIZE(RST_SIZE), .RST_SWAP(RST_SWAP)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .in_base(cfg_base), .in_size(cfg_size), .in_dev_en(cfg_dev_en),
    .in_size_en(cfg_size_en), .in_swap(cfg_swap),
    .cur_base(cur_base), .cur_size(cur_size), .cur_dev_en(cur_dev_en),
    .cur_size_en(cur_size_en), .cur_swap(cur_swap)
  );

  bridge_screen #(.ADDR_W(ADDR_W)) i_screen (
    .base(cur_base), .size(cur_size), .dev_en(cur_dev_en), .size_en(cur_size_en),
    .acc_size(req_size), .offset(req_offset), .verdict(verdict), .abs_addr(abs_addr)
  );

  assign st_size = (state == ST_IDLE) ? req_size      : t_size;
  assign st_low  = (state == ST_IDLE) ? abs_addr[1:0] : t_low;
  assign st_swap = (state == ST_IDLE) ? cur_swap      : t_swap;

  bridge_lanes i_lanes (
    .acc_size(st_size), .low(st_low), .swap(st_swap),
    .proc_wdata(req_wdata), .ext_rdata(ext_rdata),
    .mask(st_mask), .ext_wdata(st_wdata), .proc_rdata(st_rdata)
  );

  assign req_ready  = (state == ST_IDLE);
  assign accept_evt = req_valid && req_ready;
  assign go_evt     = accept_evt && (verdict == VD_GO);
  assign drop_evt   = accept_evt && (verdict != VD_GO);
  assign done_evt   = (state == ST_EXT) && ext_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      t_size     <= 2'b00;
      t_low      <= 2'b00;
      t_swap     <= 1'b0;
      t_write    <= 1'b0;
      ext_valid  <= 1'b0;
      ext_write  <= 1'b0;
      ext_addr   <= '0;
      ext_mask   <= '0;
      ext_wdata  <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      flag_nosel <= 1'b0;
      flag_range <= 1'b0;
      flag_align <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      flag_nosel <= 1'b0;
      flag_range <= 1'b0;
      flag_align <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept_evt) begin
            t_size  <= req_size;
            t_low   <= abs_addr[1:0];
            t_swap  <= cur_swap;
            t_write <= req_write;
            if (go_evt) begin
              ext_valid <= 1'b1;
              ext_write <= req_write;
              ext_addr  <= {abs_addr[ADDR_W-1:2], 2'b00};
              ext_mask  <= st_mask;
              ext_wdata <= req_write ? st_wdata : '0;
              state     <= ST_EXT;
            end else begin
              rsp_valid  <= 1'b1;
              rsp_rdata  <= '0;
              flag_nosel <= (verdict == VD_NOSEL);
              flag_range <= (verdict == VD_RANGE);
              flag_align <= (verdict == VD_ALIGN);
              state      <= ST_RSP;
            end
          end
        end
        ST_EXT: begin
          if (ext_ack) begin
            ext_valid <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_rdata <= t_write ? '0 : st_rdata;
            state     <= ST_RSP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/subword_bridge_chk.sv
module subword_bridge_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ext_valid,
  input logic              ext_ack,
  input logic              ext_write,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [3:0]        ext_mask,
  input logic [31:0]       ext_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              flag_nosel,
  input logic              flag_range,
  input logic              flag_align,
  input logic              drop_evt,
  input logic              done_evt
);

  logic [31:0] lane_bits;
  assign lane_bits = {{8{ext_mask[3]}}, {8{ext_mask[2]}}, {8{ext_mask[1]}}, {8{ext_mask[0]}}};

  // R2
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && !ext_ack |=> ext_valid && $stable(ext_addr) && $stable(ext_mask));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> ext_addr[1:0] == 2'b00);

  // R3
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> (ext_mask == 4'b0001 || ext_mask == 4'b0010 || ext_mask == 4'b0100 ||
                   ext_mask == 4'b1000 || ext_mask == 4'b0011 || ext_mask == 4'b1100 ||
                   ext_mask == 4'b1111));

  // R3
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && ext_write |-> (ext_wdata & ~lane_bits) == 32'h0);

  // R6
  drop_noext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !ext_valid && rsp_valid);

  // R5
  drop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_nosel || flag_range || flag_align) |-> rsp_valid && rsp_rdata == 32'h0);

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_nosel, flag_range, flag_align}));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  ack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rsp_valid && !ext_valid);

endmodule

bind subword_bridge subword_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ext_valid(ext_valid),
  .ext_ack(ext_ack), .ext_write(ext_write), .ext_addr(ext_addr), .ext_mask(ext_mask),
  .ext_wdata(ext_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .flag_nosel(flag_nosel), .flag_range(flag_range), .flag_align(flag_align),
  .drop_evt(drop_evt), .done_evt(done_evt)
);

// File: tb/test_subword_bridge.sv
module test_subword_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_base = '0, cfg_size = '0;
  logic        cfg_dev_en = 1'b1;
  logic [2:0]  cfg_size_en = 3'b111;
  logic        cfg_swap = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_offset = '0, req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        ext_valid, ext_write;
  logic [31:0] ext_addr, ext_wdata;
  logic [3:0]  ext_mask;
  logic        ext_ack = 1'b0;
  logic [31:0] ext_rdata = '0;
  logic        flag_nosel, flag_range, flag_align;

  always #10 clk = ~clk;

  subword_bridge i_subword_bridge (.*);

  int checks = 0;
  int failures = 0;
  int ack_gap = 0;

  typedef struct { logic [31:0] rdata; logic nosel, rng, aln; string tag; } rsp_t;
  typedef struct { logic wr; logic [31:0] addr; logic [3:0] mask; logic [31:0] wdata; string tag; } ext_t;
  rsp_t rq[$];
  ext_t xq[$];

  // bench-side configuration shadow
  logic [31:0] m_base = '0, m_size = '0;
  logic        m_dev = 1'b1, m_swap = 1'b0;
  logic [2:0]  m_en = 3'b111;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_model(input logic [31:0] a);
    return {a[7:0] ^ 8'hA1, a[7:0] ^ 8'hB2, a[7:0] ^ 8'hC3, a[7:0] ^ 8'hD4};
  endfunction

  function automatic logic [31:0] rev_bytes(input logic [31:0] w);
    return {<<8{w}};
  endfunction

  function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'd0) return 4'b0001 << a[1:0];
    if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] spread(input logic [3:0] m);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [31:0] a, input logic sw, input logic [31:0] d);
    logic [15:0] h;
    if (sz == 2'd0) return {4{d[7:0]}} & spread(exp_mask(sz, a));
    if (sz == 2'd1) begin
      h = sw ? {d[7:0], d[15:8]} : d[15:0];
      return {2{h}} & spread(exp_mask(sz, a));
    end
    return sw ? rev_bytes(d) : d;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [1:0] sz, input logic [31:0] a, input logic sw, input logic [31:0] w);
    logic [15:0] h;
    if (sz == 2'd0) return (w >> (8 * a[1:0])) & 32'hFF;
    if (sz == 2'd1) begin
      h = a[1] ? w[31:16] : w[15:0];
      return {16'h0, sw ? {h[7:0], h[15:8]} : h};
    end
    return sw ? rev_bytes(w) : w;
  endfunction

  task automatic set_cfg(input logic [31:0] b, input logic [31:0] s, input logic dv, input logic [2:0] en, input logic sw);
    @(negedge clk);
    cfg_base = b; cfg_size = s; cfg_dev_en = dv; cfg_size_en = en; cfg_swap = sw;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_base = b; m_size = s; m_dev = dv; m_en = en; m_swap = sw;
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] off,
                        input logic [31:0] wd, input string tag);
    rsp_t e;
    ext_t x;
    logic [31:0] a;
    logic claim, mis;
    a = m_base + off;
    claim = m_dev && (m_size != 0) && (m_en != 0) && (sz != 2'd3) && m_en[sz];
    mis = (sz == 2'd1 && off[0]) || (sz == 2'd2 && off[1:0] != 2'b00);
    e.nosel = !claim;
    e.rng = claim && (off >= m_size);
    e.aln = claim && !e.rng && mis;
    e.tag = tag;
    e.rdata = '0;
    if (!e.nosel && !e.rng && !e.aln) begin
      x.wr = wr; x.addr = a & ~32'h3; x.mask = exp_mask(sz, a);
      x.wdata = wr ? exp_wdata(sz, a, m_swap, wd) : '0;
      x.tag = tag;
      xq.push_back(x);
      if (!wr) e.rdata = exp_rdata(sz, a, m_swap, word_model(x.addr));
    end
    rq.push_back(e);
    req_write = wr; req_size = sz; req_offset = off; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
  endtask

  // external responder: checks each transaction and acknowledges it
  initial begin
    forever begin
      @(negedge clk);
      ext_ack = 1'b0;
      if (ext_valid) begin
        if (xq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R9 unexpected external transaction actual=%h expected=none", ext_addr);
        end else begin
          ext_t x;
          x = xq.pop_front();
          chk(x.tag, "ext_write", {31'h0, ext_write}, {31'h0, x.wr});
          chk(x.tag, "ext_addr", ext_addr, x.addr);
          chk(x.tag, "ext_mask", {28'h0, ext_mask}, {28'h0, x.mask});
          chk(x.tag, "ext_wdata", ext_wdata, x.wdata);
        end
        repeat (ack_gap) @(negedge clk);
        ext_rdata = word_model(ext_addr);
        ext_ack = 1'b1;
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ext_valid && req_ready) begin
        checks++; failures++;
        $display("FAIL R9 req_ready while busy actual=1 expected=0");
      end
      if (rst_n && rsp_valid) begin
        if (rq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R9 unexpected response actual=%h expected=none", rsp_rdata);
        end else begin
          rsp_t e;
          e = rq.pop_front();
          chk(e.tag, "rsp_rdata", rsp_rdata, e.rdata);
          chk(e.tag, "flags", {29'h0, flag_nosel, flag_range, flag_align}, {29'h0, e.nosel, e.rng, e.aln});
        end
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1", "ext_valid", {31'h0, ext_valid}, 32'h0);
    chk("R1", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 2'd2, 32'h0, 32'h0, "R1");
    access(1'b0, 2'd0, 32'h0, 32'h0, "R1");

    set_cfg(32'h0000_1000, 32'h40, 1'b1, 3'b111, 1'b0);
    ack_gap = 1;
    // R2 / R4 word
    access(1'b1, 2'd2, 32'h8, 32'h1122_3344, "R2");
    access(1'b0, 2'd2, 32'h1C, 32'h0, "R4");
    // R3 bytes every lane
    for (int i = 0; i < 4; i++) access(1'b1, 2'd0, 32'h10 + i, 32'hFFFF_FF00 | (8'h5A + i), "R3");
    for (int i = 0; i < 4; i++) access(1'b0, 2'd0, 32'h20 + i, 32'h0, "R3");
    // R4 half both positions
    ack_gap = 2;
    access(1'b1, 2'd1, 32'h4, 32'hDEAD_BEEF, "R4");
    access(1'b1, 2'd1, 32'h6, 32'hCAFE_0123, "R4");
    access(1'b0, 2'd1, 32'h4, 32'h0, "R4");
    access(1'b0, 2'd1, 32'h2E, 32'h0, "R4");
    // R5 misalignment
    ack_gap = 0;
    access(1'b1, 2'd1, 32'h5, 32'h1234_5678, "R5");
    access(1'b0, 2'd2, 32'h6, 32'h0, "R5");
    access(1'b0, 2'd2, 32'h1, 32'h0, "R5");
    // R6 window boundary
    access(1'b0, 2'd0, 32'h3F, 32'h0, "R6");
    access(1'b1, 2'd0, 32'h40, 32'h77, "R6");
    access(1'b0, 2'd2, 32'hFFFF_0000, 32'h0, "R6");
    // R10 priority: out of window beats misaligned
    access(1'b0, 2'd1, 32'h41, 32'h0, "R10");
    // R8 swap
    set_cfg(32'h0000_1000, 32'h40, 1'b1, 3'b111, 1'b1);
    access(1'b1, 2'd1, 32'h6, 32'h0000_A1B2, "R8");
    access(1'b0, 2'd1, 32'h0, 32'h0, "R8");
    access(1'b1, 2'd2, 32'hC, 32'h0102_0304, "R8");
    access(1'b0, 2'd2, 32'h18, 32'h0, "R8");
    access(1'b0, 2'd0, 32'h11, 32'h0, "R8");
    access(1'b1, 2'd0, 32'h12, 32'h0000_00E7, "R8");
    // R10 config load landing on the acknowledge edge of a pending read
    ack_gap = 0;
    fork
      access(1'b0, 2'd1, 32'h22, 32'h0, "R10");
      begin
        wait (ext_valid);
        set_cfg(32'h0000_1000, 32'h40, 1'b1, 3'b111, 1'b0);
      end
    join
    access(1'b0, 2'd1, 32'h22, 32'h0, "R10");
    // R7 not-claimed cases
    set_cfg(32'h0000_2000, 32'h100, 1'b1, 3'b101, 1'b0);
    access(1'b1, 2'd1, 32'h10, 32'h5555, "R7");
    access(1'b1, 2'd0, 32'h13, 32'h0000_0099, "R7");
    access(1'b0, 2'd3, 32'h10, 32'h0, "R7");
    access(1'b0, 2'd1, 32'h200, 32'h0, "R10");
    set_cfg(32'h0000_2000, 32'h100, 1'b1, 3'b000, 1'b0);
    access(1'b0, 2'd0, 32'h4, 32'h0, "R7");
    set_cfg(32'h0000_2000, 32'h100, 1'b0, 3'b111, 1'b0);
    access(1'b0, 2'd2, 32'h4, 32'h0, "R7");
    set_cfg(32'h0000_2000, 32'h0, 1'b1, 3'b111, 1'b0);
    access(1'b1, 2'd2, 32'h0, 32'h1, "R7");
    // R9 nothing left outstanding
    repeat (4) @(negedge clk);
    chk("R9", "pending ext", xq.size(), 32'h0);
    chk("R9", "pending rsp", rq.size(), 32'h0);
    finish_run();
  end

endmodule